// File: doc/BRIEF.md
# Cartridge-Side CPU Reset Detector

This block sits on a game cartridge and infers, from the CPU bus alone, that the console CPU has been reset. Mapper registers can then be returned to a known state even though the cartridge connector carries no reset line. It watches the CPU clock (M2), the 16-bit address bus and the read/write strobe. It produces a register-reset pulse that lasts one CPU cycle, plus a sticky flag for a suspected CPU halt.

A parameter selects one of two detectors.

- **Vector mode** fires when the CPU reads the low byte of the reset vector at `$FFFC`. A second parameter sets how many upper address bits take part in the compare, which trades decoder width against aliasing.
- **A0 mode** relies on a property of legal code: address bit 0 always toggles within one instruction, because every instruction fetches its opcode and the next sequential byte. When A0 holds one value for a run of CPU cycles longer than any legal instruction, the mode fires. If no reset-vector read preceded such a run, the cause is taken to be a halting opcode, and the jam flag is raised.

All bus inputs are synchronized into a fast cartridge clock. The bus is sampled once per CPU cycle, at the falling edge of M2.

Top module: `cart_rst_detect`

## Requirements
- R1: Address and R/W are taken only at the falling edge of M2. Bus values that are present earlier in the M2-high phase but gone by the fall have no effect.
- R2: In vector mode, a read (`rw_i`=1) of `$FFFC` while armed raises `rst_pulse_o`. The pulse is held for exactly one CPU cycle, until the next M2 falling-edge sample.
- R3: In vector mode, a write (`rw_i`=0) to `$FFFC` never raises the pulse.
- R4: In vector mode, after a pulse no further pulse occurs until a sampled address lies outside the vector region. With a full compare, the vector region is `$FFFC`–`$FFFD`. Repeated reads of `$FFFC` therefore give a single pulse.
- R5: With `CMP_BITS` below 16, only the upper `CMP_BITS` address bits are compared with `$FFFC`, and the region used for re-arming is the same range. For example, with 12 bits every read of `$FFF0`–`$FFFF` is a match.
- R6: In A0 mode, the pulse rises on the sample where A0 has held the same value for `STUCK_CYCLES` consecutive samples (default 8). Shorter runs never fire.
- R7: In A0 mode, after a pulse no further pulse occurs until A0 toggles, however long A0 remains stuck.
- R8: In A0 mode, `jam_flag_o` is set when a stuck run fires and no read of `$FFFC`/`$FFFD` has occurred since power-on or since the previous firing. The flag stays set until `rst_ni` is asserted.
- R9: `rst_ni` low clears the pulse, the jam flag, the stuck run and the stored A0 value. The first sample after reset starts a run of length 1, and both detectors come out of reset armed.
- R10: In vector mode, `jam_flag_o` is always 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Cartridge sampling clock, much faster than M2 |
| rst_ni | input | 1 | Asynchronous active-low power-on reset |
| m2_i | input | 1 | CPU clock M2; the bus is valid at its falling edge |
| addr_i | input | 16 | CPU address bus |
| rw_i | input | 1 | CPU read/write strobe, 1 = read |
| rst_pulse_o | output | 1 | Register-reset pulse, one CPU cycle wide |
| jam_flag_o | output | 1 | Sticky flag: A0 stall with no preceding vector read |

## Verification
The path from a falling edge of M2 to a new value on `rst_pulse_o` or `jam_flag_o` has four rising edges of `clk_i`: two synchronizer stages, the capture of the sample, and the detector register. The result then holds until the same point after the next M2 fall. Each bench CPU cycle keeps M2 high for 8 clocks and low for 8 clocks. The outputs are read on the clock falling edge just before the next M2 rise. That instant is eight clocks after the fall, so it is always inside the window that belongs to the cycle just driven. A reference model advances one step per CPU cycle, and each read is compared against it.

// File: rtl/cart_rst_detect_pkg.sv
package cart_rst_detect_pkg;
  typedef enum logic {
    DET_VECTOR = 1'b0,
    DET_A0     = 1'b1
  } det_mode_e;

  localparam int unsigned ADDR_W = 16;
  localparam logic [ADDR_W-1:0] RESET_VEC = 16'hFFFC;
endpackage

// File: rtl/rdet_sync.sv
module rdet_sync #(
  parameter int unsigned WIDTH  = 1,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [STAGES-1:0][WIDTH-1:0] stg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stg_q <= '0;
    end else begin
      stg_q[0] <= d_i;
      for (int s = 1; s < STAGES; s++) stg_q[s] <= stg_q[s-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/rdet_sampler.sv
module rdet_sampler
  import cart_rst_detect_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              m2_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              rw_i,
  output logic              smp_valid_o,
  output logic [ADDR_W-1:0] smp_addr_o,
  output logic              smp_rw_o
);
  localparam int unsigned BUS_W = ADDR_W + 2;

  logic [BUS_W-1:0]  bus_s;
  logic              m2_s, rw_s, m2_q, m2_fall;
  logic [ADDR_W-1:0] addr_s;
  logic              valid_q, rw_q;
  logic [ADDR_W-1:0] addr_q;

  rdet_sync #(.WIDTH(BUS_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({m2_i, rw_i, addr_i}),
    .q_o   (bus_s)
  );

  assign {m2_s, rw_s, addr_s} = bus_s;
  assign m2_fall = m2_q & ~m2_s;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m2_q    <= 1'b0;
      valid_q <= 1'b0;
      addr_q  <= '0;
      rw_q    <= 1'b0;
    end else begin
      m2_q    <= m2_s;
      valid_q <= m2_fall;
      if (m2_fall) begin
        addr_q <= addr_s;
        rw_q   <= rw_s;
      end
    end
  end

  assign smp_valid_o = valid_q;
  assign smp_addr_o  = addr_q;
  assign smp_rw_o    = rw_q;

  AST_SMP_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_q |=> !valid_q); // R1
  AST_SMP_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !m2_fall |=> $stable(addr_q) && $stable(rw_q)); // R1
endmodule

// File: rtl/rdet_vec_match.sv
module rdet_vec_match
  import cart_rst_detect_pkg::*;
#(
  parameter int unsigned CMP_BITS = 16
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic              hit_o,
  output logic              region_o
);
  // Region ignores bit 0 at full width so $FFFD does not re-arm.
  localparam int unsigned REGION_BITS = (CMP_BITS > ADDR_W - 1) ? ADDR_W - 1 : CMP_BITS;

  assign hit_o    = addr_i[ADDR_W-1 -: CMP_BITS] == RESET_VEC[ADDR_W-1 -: CMP_BITS];
  assign region_o = addr_i[ADDR_W-1 -: REGION_BITS] == RESET_VEC[ADDR_W-1 -: REGION_BITS];
endmodule

// File: rtl/rdet_vec_det.sv
module rdet_vec_det
  import cart_rst_detect_pkg::*;
#(
  parameter int unsigned CMP_BITS = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              smp_valid_i,
  input  logic [ADDR_W-1:0] smp_addr_i,
  input  logic              smp_rw_i,
  output logic              pulse_o
);
  logic hit, region, fire, armed_q, pulse_q;

  rdet_vec_match #(.CMP_BITS(CMP_BITS)) u_match (
    .addr_i  (smp_addr_i),
    .hit_o   (hit),
    .region_o(region)
  );

  assign fire = armed_q & hit & smp_rw_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q <= 1'b1;
      pulse_q <= 1'b0;
    end else if (smp_valid_i) begin
      pulse_q <= fire;
      if (!region)   armed_q <= 1'b1;
      else if (fire) armed_q <= 1'b0;
    end
  end

  assign pulse_o = pulse_q;

  AST_VEC_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !smp_valid_i |=> $stable(pulse_q)); // R2
  AST_VEC_READ_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pulse_q) |-> $past(smp_rw_i)); // R3
  AST_VEC_NO_REFIRE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (smp_valid_i && pulse_q && region) |=> !pulse_q); // R4
endmodule

// File: rtl/rdet_a0_det.sv
module rdet_a0_det
  import cart_rst_detect_pkg::*;
#(
  parameter int unsigned STUCK_CYCLES = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              smp_valid_i,
  input  logic [ADDR_W-1:0] smp_addr_i,
  input  logic              smp_rw_i,
  output logic              pulse_o,
  output logic              jam_o
);
  localparam int unsigned RUN_W = $clog2(STUCK_CYCLES + 1);
  localparam logic [RUN_W-1:0] RUN_MAX = RUN_W'(STUCK_CYCLES);

  logic             first_q, last_a0_q, armed_q, seen_q, pulse_q, jam_q;
  logic [RUN_W-1:0] run_q, run_d;
  logic             toggle, armed_eff, fire, vec_read, seen_eff;

  assign toggle    = first_q | (smp_addr_i[0] != last_a0_q);
  assign run_d     = toggle ? RUN_W'(1) : ((run_q == RUN_MAX) ? RUN_MAX : run_q + RUN_W'(1));
  assign armed_eff = toggle | armed_q;
  assign fire      = armed_eff & (run_d == RUN_MAX);
  assign vec_read  = smp_rw_i & (smp_addr_i[ADDR_W-1:1] == RESET_VEC[ADDR_W-1:1]);
  assign seen_eff  = seen_q | vec_read;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      first_q   <= 1'b1;
      last_a0_q <= 1'b0;
      run_q     <= '0;
      armed_q   <= 1'b1;
      seen_q    <= 1'b0;
      pulse_q   <= 1'b0;
      jam_q     <= 1'b0;
    end else if (smp_valid_i) begin
      first_q   <= 1'b0;
      last_a0_q <= smp_addr_i[0];
      run_q     <= run_d;
      armed_q   <= armed_eff & ~fire;
      pulse_q   <= fire;
      seen_q    <= seen_eff & ~fire;
      if (fire && !seen_eff) jam_q <= 1'b1;
    end
  end

  assign pulse_o = pulse_q;
  assign jam_o   = jam_q;

  AST_A0_RUN_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q <= RUN_MAX); // R6
  AST_A0_FIRE_AT_LIMIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pulse_q) |-> (run_q == RUN_MAX)); // R6
  AST_A0_NO_REFIRE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (smp_valid_i && pulse_q && !first_q && (smp_addr_i[0] == last_a0_q)) |=> !pulse_q); // R7
  AST_A0_JAM_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    jam_q |=> jam_q); // R8
endmodule

// File: rtl/cart_rst_detect.sv
module cart_rst_detect
  import cart_rst_detect_pkg::*;
#(
  parameter det_mode_e   MODE         = DET_VECTOR,
  parameter int unsigned CMP_BITS     = 16,
  parameter int unsigned STUCK_CYCLES = 8,
  parameter int unsigned SYNC_STAGES  = 2
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        m2_i,
  input  logic [15:0] addr_i,
  input  logic        rw_i,
  output logic        rst_pulse_o,
  output logic        jam_flag_o
);
  logic              smp_valid, smp_rw;
  logic [ADDR_W-1:0] smp_addr;

  rdet_sampler #(.SYNC_STAGES(SYNC_STAGES)) u_sampler (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .m2_i       (m2_i),
    .addr_i     (addr_i),
    .rw_i       (rw_i),
    .smp_valid_o(smp_valid),
    .smp_addr_o (smp_addr),
    .smp_rw_o   (smp_rw)
  );

  if (MODE == DET_VECTOR) begin : g_vec
    rdet_vec_det #(.CMP_BITS(CMP_BITS)) u_det (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .smp_valid_i(smp_valid),
      .smp_addr_i (smp_addr),
      .smp_rw_i   (smp_rw),
      .pulse_o    (rst_pulse_o)
    );
    assign jam_flag_o = 1'b0;
  end else begin : g_a0
    rdet_a0_det #(.STUCK_CYCLES(STUCK_CYCLES)) u_det (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .smp_valid_i(smp_valid),
      .smp_addr_i (smp_addr),
      .smp_rw_i   (smp_rw),
      .pulse_o    (rst_pulse_o),
      .jam_o      (jam_flag_o)
    );
  end
endmodule

// File: tb/cart_rst_detect_bench.sv
module cart_rst_detect_bench;
  import cart_rst_detect_pkg::*;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        m2 = 1'b0;
  logic [15:0] addr = 16'h0000;
  logic        rw = 1'b1;
  logic        vf_pulse, vf_jam, vp_pulse, vp_jam, a_pulse, a_jam;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  cart_rst_detect u_cart_rst_detect (
    .clk_i(clk), .rst_ni(rst_n), .m2_i(m2), .addr_i(addr), .rw_i(rw),
    .rst_pulse_o(vf_pulse), .jam_flag_o(vf_jam));

  cart_rst_detect #(.CMP_BITS(12)) u_cart_rst_detect_part (
    .clk_i(clk), .rst_ni(rst_n), .m2_i(m2), .addr_i(addr), .rw_i(rw),
    .rst_pulse_o(vp_pulse), .jam_flag_o(vp_jam));

  cart_rst_detect #(.MODE(DET_A0), .STUCK_CYCLES(8)) u_cart_rst_detect_a0 (
    .clk_i(clk), .rst_ni(rst_n), .m2_i(m2), .addr_i(addr), .rw_i(rw),
    .rst_pulse_o(a_pulse), .jam_flag_o(a_jam));

  // reference model state
  bit vf_armed, vp_armed, vf_exp, vp_exp;
  bit a_first, a_last, a_armed, a_seen, a_jam_exp, a_exp;
  int a_run;

  task automatic model_reset();
    vf_armed = 1; vp_armed = 1; vf_exp = 0; vp_exp = 0;
    a_first = 1; a_last = 0; a_armed = 1; a_seen = 0; a_jam_exp = 0; a_exp = 0; a_run = 0;
  endtask

  task automatic model_step(input logic [15:0] a, input logic r);
    bit reg_f, hit_f, hit_p, tog, arm_e, seen_e;
    reg_f = (a[15:1] == 15'h7FFE);
    hit_f = (a == 16'hFFFC);
    hit_p = (a[15:4] == 12'hFFF);
    vf_exp = vf_armed && hit_f && r;
    vf_armed = !reg_f ? 1'b1 : (vf_exp ? 1'b0 : vf_armed);
    vp_exp = vp_armed && hit_p && r;
    vp_armed = !hit_p ? 1'b1 : (vp_exp ? 1'b0 : vp_armed);
    tog = a_first || (a[0] != a_last);
    a_first = 0;
    a_last = a[0];
    a_run = tog ? 1 : ((a_run + 1 > 8) ? 8 : a_run + 1);
    arm_e = tog || a_armed;
    a_exp = arm_e && (a_run == 8);
    a_armed = arm_e && !a_exp;
    seen_e = a_seen || (reg_f && r);
    if (a_exp) begin
      if (!seen_e) a_jam_exp = 1;
      a_seen = 0;
    end else begin
      a_seen = seen_e;
    end
  endtask

  task automatic check(input string tag, input string what, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0b expected=%0b at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic check_all(input string vtag, input string atag);
    check(vtag, "full vector pulse", vf_pulse, vf_exp);
    check("R10", "vector jam flag", vf_jam, 1'b0);
    check("R5", "partial compare pulse", vp_pulse, vp_exp);
    check(atag, "a0 pulse", a_pulse, a_exp);
    check("R8", "a0 jam flag", a_jam, a_jam_exp);
  endtask

  // One CPU cycle: pre-address early in M2 high, final address at the fall.
  task automatic cyc_pre(input logic [15:0] pre, input logic [15:0] a, input logic r,
                         input string vtag, input string atag);
    m2 = 1; addr = pre; rw = r;
    repeat (4) @(negedge clk);
    addr = a;
    repeat (4) @(negedge clk);
    m2 = 0;
    repeat (8) @(negedge clk);
    model_step(a, r);
    check_all(vtag, atag);
  endtask

  task automatic cyc(input logic [15:0] a, input logic r, input string vtag, input string atag);
    cyc_pre(a, a, r, vtag, atag);
  endtask

  task automatic do_reset();
    rst_n = 0; m2 = 0;
    repeat (4) @(negedge clk);
    model_reset();
    check("R9", "full pulse in reset", vf_pulse, 1'b0);
    check("R9", "a0 pulse in reset", a_pulse, 1'b0);
    check("R9", "a0 jam in reset", a_jam, 1'b0);
    rst_n = 1;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    @(negedge clk);
    do_reset();

    // R6: sequential fetches keep A0 toggling
    for (int i = 0; i < 20; i++) cyc(16'h8000 + 16'(i), 1'b1, "R2", "R6");
    // R6: run of 7 equal A0 values never fires
    for (int i = 0; i < 7; i++) cyc(16'h0100 + 16'(2 * i), 1'b1, "R2", "R6");
    cyc(16'h0101, 1'b1, "R2", "R6");

    // R2/R4: vector fetch sequence and re-arm
    cyc(16'hFFFC, 1'b1, "R2", "R6");
    cyc(16'hFFFD, 1'b1, "R2", "R6");
    cyc(16'hFFFC, 1'b1, "R4", "R6");
    cyc(16'hFFFC, 1'b1, "R4", "R6");
    cyc(16'h8001, 1'b1, "R4", "R6");
    cyc(16'hFFFC, 1'b1, "R4", "R6");
    cyc(16'h8003, 1'b1, "R4", "R6");
    // R3: write to vector never fires
    cyc(16'hFFFC, 1'b0, "R3", "R6");
    cyc(16'h8004, 1'b1, "R3", "R6");
    // R1: only the address present at the M2 fall counts
    cyc_pre(16'hFFFC, 16'h8005, 1'b1, "R1", "R6");
    cyc_pre(16'h8006, 16'hFFFC, 1'b1, "R1", "R6");
    cyc(16'h8007, 1'b1, "R1", "R6");

    // R2/R5: sweep the top page, reads then writes, with re-arm between
    for (int i = 0; i < 256; i++) begin
      cyc(16'hFF00 + 16'(i), 1'b1, "R2", "R6");
      if (i[1:0] == 2'd3) cyc(16'h4000 + 16'(i), 1'b1, "R4", "R6");
    end
    for (int i = 0; i < 256; i++) cyc(16'hFF00 + 16'(i), 1'b0, "R3", "R6");

    // R7: stall after vector reads (no jam), then stall again (jam)
    cyc(16'hFFFC, 1'b1, "R2", "R7");
    for (int i = 0; i < 12; i++) cyc(16'h8002, 1'b1, "R2", "R7");
    cyc(16'h8003, 1'b1, "R2", "R7");
    for (int i = 0; i < 10; i++) cyc(16'hC000, 1'b1, "R2", "R8");
    for (int i = 0; i < 4; i++) cyc(16'hC001 + 16'(i), 1'b1, "R2", "R8");
    // R8: vector read before the stall keeps the flag as is
    cyc(16'hFFFD, 1'b1, "R2", "R8");
    for (int i = 0; i < 9; i++) cyc(16'h0103, 1'b1, "R2", "R8");

    // R9: reset clears jam; first sample starts a run of 1
    do_reset();
    for (int i = 0; i < 9; i++) cyc(16'h0200, 1'b0, "R9", "R9");
    cyc(16'h0201, 1'b1, "R9", "R9");
    cyc(16'hFFFC, 1'b1, "R9", "R9");

    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule